// File: doc/BRIEF.md
# Multicore Interrupt Routing Controller

This block sits between a set of interrupt sources and four processor cores, deciding for every source which core sees it and whether it arrives as a fast interrupt (FIQ) or a normal interrupt (IRQ). Each core has four local timer request lines and four mailbox-pending flags. Two eight-bit control registers per core steer these lines: one for the timer lines and one for the mailbox flags. One shared upstream IRQ line and one shared upstream FIQ line are each steered to a single core by a routing register.

Software programs the block over a simple 32-bit register bus. A write is accepted in the cycle where `bus_sel` and `bus_wr` are both high. A read returns data combinationally on `bus_rdata` while `bus_sel` is high and `bus_wr` is low; `bus_rdata` is zero at all other times.

Each core has two read-only source registers, one for IRQ and one for FIQ, that show which sources are currently asserted toward it. The per-core `core_irq` and `core_fiq` outputs are the OR of those registers, and each passes through one flip-flop so that every core sees a glitch-free level.

Top module: `mc_irq_router`

## Requirements
- R1: Reset clears the routing register and every timer and mailbox control register to zero, and drives `core_irq` and `core_fiq` low.
- R2: For core c, local line n is bit c*4+n of `tmr_req` (or of `mbx_pend`). Bit n of that core's matching control register (timer control at 0x40+4*c, mailbox control at 0x50+4*c) enables IRQ delivery of the line. An active, IRQ-enabled line with its FIQ bit clear sets source bit n (timer) or bit n+4 (mailbox) of the IRQ source register at 0x60+4*c, and the same bit of the FIQ source register stays clear.
- R3: Bit n+4 of the same control register enables FIQ delivery and takes precedence. An active line with that bit set appears only in the FIQ source register at 0x70+4*c, whatever its IRQ bit holds.
- R4: An active line whose IRQ and FIQ enable bits are both clear is masked. It sets no bit in either source register and raises no output.
- R5: Mailbox flags use source bits 4 to 7 and are steered by the mailbox control register, independently of the timer control register, which steers source bits 0 to 3.
- R6: The routing register sits at 0x0C. Bits [1:0] name the core whose IRQ source bit 8 follows `up_irq`, and bits [3:2] name the core whose FIQ source bit 8 follows `up_fiq`. No other core's bit 8 is ever set. A read returns these four bits, with all higher bits zero.
- R7: A write to a control register stores only data bits [7:0]. A read returns them, with bits [31:8] zero.
- R8: The source registers are read-only: writes to 0x60 to 0x7C change nothing. Bits 9 to 31 of every source register always read 0.
- R9: Any offset not listed above, and any offset with address bits [1:0] nonzero, reads 0. A write to such an offset changes no register.
- R10: In each cycle, `core_irq[c]` equals the OR of core c's IRQ source register as it stood one clock edge earlier, and `core_fiq[c]` does the same with the FIQ source register.
- R11: A routing or control register write accepted at clock edge E changes the outputs at edge E+1, not at edge E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tmr_req | input | 16 | Local timer lines, core c line n at bit c*4+n |
| mbx_pend | input | 16 | Mailbox-pending flags, core c mailbox n at bit c*4+n |
| up_irq | input | 1 | Shared upstream IRQ request |
| up_fiq | input | 1 | Shared upstream FIQ request |
| core_irq | output | 4 | Registered IRQ level per core |
| core_fiq | output | 4 | Registered FIQ level per core |

## Verification
The main steering function is driven with control bytes that enable only IRQ, only FIQ, both, or neither, each crossed with several active-line patterns. Mixed bytes such as 0x35 and 0x21 place IRQ-only, FIQ-only and masked lines in the same register, so the result shows whether precedence is applied per bit rather than per register. Mailbox patterns run with the timer control at zero, and the reverse, which separates the two control registers. Directed tests cover the routing register with distinct IRQ and FIQ targets, the one-edge write-to-output latency, writes to read-only and unmapped offsets, and a reset in the middle of a run.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  // Fixed interrupt-source layout shared by the register map and the steering logic.
  localparam int LOCAL_W  = 4;               // local lines per group (timer or mailbox)
  localparam int CTRL_W   = 2 * LOCAL_W;     // control byte: IRQ enables low, FIQ enables high
  localparam int SRC_W    = 12;              // meaningful source-register width
  localparam int UP_BIT   = 2 * LOCAL_W;     // source bit of the shared upstream line
  localparam int DATA_W   = 32;

  // Register offsets (byte addresses)
  localparam int OFF_ROUTE = 'h0C;
  localparam int OFF_TCTRL = 'h40;
  localparam int OFF_MCTRL = 'h50;
  localparam int OFF_ISRC  = 'h60;
  localparam int OFF_FSRC  = 'h70;

  // Steering of one group of local lines: FIQ enable wins over IRQ enable.
  // Returns {fiq_bits, irq_bits}.
  function automatic logic [CTRL_W-1:0] steer_group(input logic [LOCAL_W-1:0] active,
                                                     input logic [CTRL_W-1:0]  ctrl);
    logic [LOCAL_W-1:0] fiq_en;
    logic [LOCAL_W-1:0] irq_en;
    fiq_en = ctrl[CTRL_W-1:LOCAL_W];
    irq_en = ctrl[LOCAL_W-1:0];
    return {active & fiq_en, active & irq_en & ~fiq_en};
  endfunction

  // Word-aligned match of an address against base + 4*index.
  function automatic logic addr_hit(input logic [7:0] addr, input int base, input int idx);
    return addr == 8'(base + 4 * idx);
  endfunction
endpackage

// File: rtl/mcr_regs.sv
module mcr_regs
  import mcr_pkg::*;
#(
  parameter int NC = 4,
  localparam int CW = $clog2(NC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CW-1:0]     route_irq,
  output logic [CW-1:0]     route_fiq,
  output logic [NC*CTRL_W-1:0] tctrl,
  output logic [NC*CTRL_W-1:0] mctrl,
  output logic              wr_noeffect
);
  logic hit_route;
  logic [NC-1:0] hit_t;
  logic [NC-1:0] hit_m;

  always_comb begin
    hit_route = addr_hit(addr, OFF_ROUTE, 0);
    for (int c = 0; c < NC; c++) begin
      hit_t[c] = addr_hit(addr, OFF_TCTRL, c);
      hit_m[c] = addr_hit(addr, OFF_MCTRL, c);
    end
  end

  // A write that lands on no writable register (read-only or unmapped).
  assign wr_noeffect = wr_en && !hit_route && (hit_t == '0) && (hit_m == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_irq <= '0;
      route_fiq <= '0;
      tctrl     <= '0;
      mctrl     <= '0;
    end else if (wr_en) begin
      if (hit_route) begin
        route_irq <= wdata[CW-1:0];
        route_fiq <= wdata[2*CW-1:CW];
      end
      for (int c = 0; c < NC; c++) begin
        if (hit_t[c]) tctrl[c*CTRL_W +: CTRL_W] <= wdata[CTRL_W-1:0];
        if (hit_m[c]) mctrl[c*CTRL_W +: CTRL_W] <= wdata[CTRL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mcr_steer.sv
module mcr_steer
  import mcr_pkg::*;
(
  input  logic [LOCAL_W-1:0] tmr_act,
  input  logic [LOCAL_W-1:0] mbx_act,
  input  logic [CTRL_W-1:0]  tctrl,
  input  logic [CTRL_W-1:0]  mctrl,
  input  logic               up_irq_hit,
  input  logic               up_fiq_hit,
  output logic [SRC_W-1:0]   irq_src,
  output logic [SRC_W-1:0]   fiq_src
);
  logic [CTRL_W-1:0] t_res;
  logic [CTRL_W-1:0] m_res;

  assign t_res = steer_group(tmr_act, tctrl);
  assign m_res = steer_group(mbx_act, mctrl);

  always_comb begin
    irq_src = '0;
    fiq_src = '0;
    irq_src[LOCAL_W-1:0]         = t_res[LOCAL_W-1:0];
    fiq_src[LOCAL_W-1:0]         = t_res[CTRL_W-1:LOCAL_W];
    irq_src[2*LOCAL_W-1:LOCAL_W] = m_res[LOCAL_W-1:0];
    fiq_src[2*LOCAL_W-1:LOCAL_W] = m_res[CTRL_W-1:LOCAL_W];
    irq_src[UP_BIT]              = up_irq_hit;
    fiq_src[UP_BIT]              = up_fiq_hit;
  end
endmodule

// File: rtl/mc_irq_router.sv
module mc_irq_router
  import mcr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  localparam int CW       = $clog2(NUM_CORES),
  localparam int LINES    = NUM_CORES * LOCAL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [LINES-1:0]     tmr_req,
  input  logic [LINES-1:0]     mbx_pend,
  input  logic                 up_irq,
  input  logic                 up_fiq,
  output logic [NUM_CORES-1:0] core_irq,
  output logic [NUM_CORES-1:0] core_fiq
);
  logic [CW-1:0] route_irq;
  logic [CW-1:0] route_fiq;
  logic [NUM_CORES*CTRL_W-1:0] tctrl;
  logic [NUM_CORES*CTRL_W-1:0] mctrl;
  logic wr_noeffect;
  logic [NUM_CORES*SRC_W-1:0] irq_src_flat;
  logic [NUM_CORES*SRC_W-1:0] fiq_src_flat;
  logic [2*CW+2*NUM_CORES*CTRL_W-1:0] cfg_flat;
  logic [NUM_CORES-1:0] irq_any;
  logic [NUM_CORES-1:0] fiq_any;

  mcr_regs #(.NC(NUM_CORES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_sel && bus_wr),
    .addr       (8'(bus_addr)),
    .wdata      (bus_wdata),
    .route_irq  (route_irq),
    .route_fiq  (route_fiq),
    .tctrl      (tctrl),
    .mctrl      (mctrl),
    .wr_noeffect(wr_noeffect)
  );

  assign cfg_flat = {route_fiq, route_irq, tctrl, mctrl};

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    mcr_steer u_steer (
      .tmr_act   (tmr_req[c*LOCAL_W +: LOCAL_W]),
      .mbx_act   (mbx_pend[c*LOCAL_W +: LOCAL_W]),
      .tctrl     (tctrl[c*CTRL_W +: CTRL_W]),
      .mctrl     (mctrl[c*CTRL_W +: CTRL_W]),
      .up_irq_hit(up_irq && (route_irq == CW'(c))),
      .up_fiq_hit(up_fiq && (route_fiq == CW'(c))),
      .irq_src   (irq_src_flat[c*SRC_W +: SRC_W]),
      .fiq_src   (fiq_src_flat[c*SRC_W +: SRC_W])
    );
    assign irq_any[c] = |irq_src_flat[c*SRC_W +: SRC_W];
    assign fiq_any[c] = |fiq_src_flat[c*SRC_W +: SRC_W];
  end

  // One output flop per line: glitch-free levels at the cores.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_irq <= '0;
      core_fiq <= '0;
    end else begin
      core_irq <= irq_any;
      core_fiq <= fiq_any;
    end
  end

  // Combinational read mux; unmapped or misaligned offsets read zero.
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (addr_hit(8'(bus_addr), OFF_ROUTE, 0))
        bus_rdata = DATA_W'({route_fiq, route_irq});
      for (int c = 0; c < NUM_CORES; c++) begin
        if (addr_hit(8'(bus_addr), OFF_TCTRL, c)) bus_rdata = DATA_W'(tctrl[c*CTRL_W +: CTRL_W]);
        if (addr_hit(8'(bus_addr), OFF_MCTRL, c)) bus_rdata = DATA_W'(mctrl[c*CTRL_W +: CTRL_W]);
        if (addr_hit(8'(bus_addr), OFF_ISRC, c))  bus_rdata = DATA_W'(irq_src_flat[c*SRC_W +: SRC_W]);
        if (addr_hit(8'(bus_addr), OFF_FSRC, c))  bus_rdata = DATA_W'(fiq_src_flat[c*SRC_W +: SRC_W]);
      end
    end
  end
endmodule

// File: rtl/mcr_checker.sv
module mcr_checker
  import mcr_pkg::*;
#(
  parameter int NC = 4,
  parameter int CFG_W = 68
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NC-1:0]       core_irq,
  input logic [NC-1:0]       core_fiq,
  input logic [NC*SRC_W-1:0] irq_src_flat,
  input logic [NC*SRC_W-1:0] fiq_src_flat,
  input logic [CFG_W-1:0]    cfg_flat,
  input logic                wr_noeffect
);
  logic armed;
  logic [NC-1:0] irq_any, fiq_any, up_irq_bits, up_fiq_bits;
  logic overlap, hi_set;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    overlap = 1'b0;
    hi_set  = 1'b0;
    for (int c = 0; c < NC; c++) begin
      irq_any[c]     = |irq_src_flat[c*SRC_W +: SRC_W];
      fiq_any[c]     = |fiq_src_flat[c*SRC_W +: SRC_W];
      up_irq_bits[c] = irq_src_flat[c*SRC_W + UP_BIT];
      up_fiq_bits[c] = fiq_src_flat[c*SRC_W + UP_BIT];
      overlap = overlap | (|(irq_src_flat[c*SRC_W +: UP_BIT] & fiq_src_flat[c*SRC_W +: UP_BIT]));
      hi_set  = hi_set | (|irq_src_flat[c*SRC_W+UP_BIT+1 +: SRC_W-UP_BIT-1])
                       | (|fiq_src_flat[c*SRC_W+UP_BIT+1 +: SRC_W-UP_BIT-1]);
    end
  end

  p_irq_out_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    core_irq == $past(irq_any));
  p_fiq_out_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    core_fiq == $past(fiq_any));
  p_no_dual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !overlap);
  p_hi_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_set);
  p_up_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_irq_bits) && $onehot0(up_fiq_bits));
  p_ignored_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_noeffect |=> $stable(cfg_flat));
endmodule

bind mc_irq_router mcr_checker #(.NC(NUM_CORES), .CFG_W(2*CW+2*NUM_CORES*mcr_pkg::CTRL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_irq    (core_irq),
  .core_fiq    (core_fiq),
  .irq_src_flat(irq_src_flat),
  .fiq_src_flat(fiq_src_flat),
  .cfg_flat    (cfg_flat),
  .wr_noeffect (wr_noeffect)
);

// File: tb/mc_irq_router_tb.sv
module mc_irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tmr_req = '0, mbx_pend = '0;
  logic        up_irq = 1'b0, up_fiq = 1'b0;
  logic [3:0]  core_irq, core_fiq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  mc_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_req(tmr_req), .mbx_pend(mbx_pend), .up_irq(up_irq), .up_fiq(up_fiq),
    .core_irq(core_irq), .core_fiq(core_fiq)
  );

  // {timer ctrl, mailbox ctrl, timer lines, mailbox flags, expected IRQ src, expected FIQ src}
  localparam logic [47:0] VEC [8] = '{
    {8'h0F, 8'h00, 4'hF, 4'h0, 12'h00F, 12'h000},  // IRQ only (R2)
    {8'hF0, 8'h00, 4'h5, 4'h0, 12'h000, 12'h005},  // FIQ only (R3)
    {8'hFF, 8'h00, 4'hA, 4'h0, 12'h000, 12'h00A},  // both enabled: FIQ wins (R3)
    {8'h00, 8'h00, 4'hF, 4'hF, 12'h000, 12'h000},  // masked (R4)
    {8'h00, 8'h0F, 4'h0, 4'h9, 12'h090, 12'h000},  // mailbox IRQ (R5)
    {8'h00, 8'hC3, 4'h0, 4'hF, 12'h030, 12'h0C0},  // mailbox split (R5)
    {8'h35, 8'h00, 4'h7, 4'h0, 12'h004, 12'h003},  // per-bit precedence (R3)
    {8'h21, 8'h88, 4'h3, 4'h8, 12'h001, 12'h082}   // mixed groups (R2, R5)
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_read(8'h0C, rd); check("R1 route", rd, 0);
    bus_read(8'h44, rd); check("R1 tctrl", rd, 0);
    bus_read(8'h5C, rd); check("R1 mctrl", rd, 0);
    check("R1 outputs", {24'b0, core_irq, core_fiq}, 0);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      int c;
      logic [7:0] tc, mc;
      logic [3:0] tl, ml;
      logic [11:0] ei, ef;
      c = i % 4;
      {tc, mc, tl, ml, ei, ef} = VEC[i];
      @(negedge clk);
      tmr_req = 16'(tl) << (4 * c);
      mbx_pend = 16'(ml) << (4 * c);
      bus_write(8'(8'h40 + 4 * c), 32'(tc));
      bus_write(8'(8'h50 + 4 * c), 32'(mc));
      @(negedge clk);
      bus_read(8'(8'h60 + 4 * c), rd); check($sformatf("R2/R3/R4/R5/R8 irq src vec%0d", i), rd, 32'(ei));
      bus_read(8'(8'h70 + 4 * c), rd); check($sformatf("R2/R3/R4/R5/R8 fiq src vec%0d", i), rd, 32'(ef));
      check($sformatf("R10 core_irq vec%0d", i), 32'(core_irq), 32'(ei != 0) << c);
      check($sformatf("R10 core_fiq vec%0d", i), 32'(core_fiq), 32'(ef != 0) << c);
      bus_write(8'(8'h40 + 4 * c), 0);
      bus_write(8'(8'h50 + 4 * c), 0);
      tmr_req = '0; mbx_pend = '0;
    end

    // R6: routing of the upstream lines
    bus_write(8'h0C, 32'h0000_0009);
    bus_read(8'h0C, rd); check("R6 route readback", rd, 32'h9);
    @(negedge clk); up_irq = 1'b1; up_fiq = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_read(8'h64, rd); check("R6 irq src core1", rd, 32'h100);
    bus_read(8'h60, rd); check("R6 irq src core0", rd, 32'h0);
    bus_read(8'h78, rd); check("R6 fiq src core2", rd, 32'h100);
    check("R6 core_irq", 32'(core_irq), 32'b0010);
    check("R6 core_fiq", 32'(core_fiq), 32'b0100);
    bus_write(8'h0C, 32'hFFFF_FFF6);
    bus_read(8'h0C, rd); check("R6 route packing", rd, 32'h6);
    @(negedge clk);
    check("R6 core_irq swapped", 32'(core_irq), 32'b0100);
    check("R6 core_fiq swapped", 32'(core_fiq), 32'b0010);
    up_irq = 1'b0; up_fiq = 1'b0;

    // R7: only the low byte is stored
    bus_write(8'h44, 32'hABCD_1200);
    bus_read(8'h44, rd); check("R7 low byte", rd, 32'h00);
    bus_write(8'h44, 32'h0000_0000);

    // R11: a control write reaches the outputs one edge later
    @(negedge clk); tmr_req = 16'h0001;
    @(negedge clk); @(negedge clk);
    check("R4 masked before write", 32'(core_irq), 0);
    bus_write(8'h40, 32'h01);
    check("R11 not yet at write edge", 32'(core_irq), 0);
    @(negedge clk);
    check("R11 one edge after write", 32'(core_irq), 32'b0001);

    // R8: source registers ignore writes
    bus_write(8'h60, 32'hFFFF_FFFF);
    bus_write(8'h70, 32'hFFFF_FFFF);
    bus_read(8'h60, rd); check("R8 irq src unchanged", rd, 32'h1);
    bus_read(8'h70, rd); check("R8 fiq src unchanged", rd, 32'h0);
    @(negedge clk);
    check("R8 fiq out", 32'(core_fiq), 0);

    // R9: unmapped and misaligned offsets
    bus_write(8'h10, 32'hFF);
    bus_write(8'h80, 32'hFF);
    bus_write(8'h41, 32'hF0);
    bus_write(8'h0D, 32'h0);
    bus_read(8'h40, rd); check("R9 tctrl intact", rd, 32'h01);
    bus_read(8'h0C, rd); check("R9 route intact", rd, 32'h6);
    bus_read(8'h10, rd); check("R9 read 0x10", rd, 0);
    bus_read(8'h41, rd); check("R9 misaligned read", rd, 0);
    bus_read(8'hFC, rd); check("R9 read 0xFC", rd, 0);
    @(negedge clk);
    check("R9 outputs unchanged", {24'b0, core_irq, core_fiq}, 32'h10);

    // R1: reset in mid-run clears configuration
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 outputs in reset", {24'b0, core_irq, core_fiq}, 0);
    rst_n = 1'b1;
    bus_read(8'h40, rd); check("R1 tctrl cleared", rd, 0);
    bus_read(8'h0C, rd); check("R1 route cleared", rd, 0);
    @(negedge clk);
    check("R1 output after reset", 32'(core_irq), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule